// File: doc/BRIEF.md
# Serial ADC Conversion Controller

This block runs a 12-bit serial analog-to-digital converter on the host side. The converter has three signals of interest: an active-low conversion start strobe, a BUSY status line, and a serial readout of sixteen clocks. When the host raises a start request while the controller is idle, the controller pulls the start strobe low for a set number of system clocks. It then waits for the synchronised BUSY line to go high and then low again. After that it drives exactly sixteen serial clock pulses and collects one data bit per pulse. The first four bits of the frame are expected to be zero. The low twelve bits, sent MSB first, are presented on the result port together with a one-cycle valid pulse.

The controller never toggles the serial clock while a conversion is in progress. It also never pulses the start strobe again until the current cycle is finished. Both actions are known to upset the converter. If BUSY does not complete its high-then-low sequence within a timeout, the controller takes a recovery path. It sends sixteen serial clocks, which is the only known way to free a BUSY line that is stuck high. It then sets a sticky timeout flag and returns to idle without reporting a result.

States: IDLE (ready, waiting for a request), CONV_LOW (start strobe held low), WAIT_HI (waiting for BUSY to rise), WAIT_LO (waiting for BUSY to fall), SHIFT (sixteen readout clocks), PUBLISH (result and valid driven), FLUSH (sixteen recovery clocks), FAULT (timeout flag set). Transitions:
- IDLE→CONV_LOW on a request.
- CONV_LOW→WAIT_HI when the strobe width has elapsed.
- WAIT_HI→WAIT_LO when BUSY is seen high.
- WAIT_LO→SHIFT when BUSY is seen low.
- WAIT_HI or WAIT_LO→FLUSH when the timeout expires.
- SHIFT→PUBLISH and FLUSH→FAULT on the sixteenth pulse.
- PUBLISH→IDLE and FAULT→IDLE unconditionally.

Top module: `adc_conv_ctrl`

## Requirements
- R1: After reset, ready is 1, the start strobe is 1 (inactive), the serial clock is 1, result is 0, and result_valid, err_timeout and err_frame are 0.
- R2: A start request seen while ready is 1 drives the start strobe low for exactly START_LOW_CYC consecutive clock cycles. This happens exactly once per request, and ready drops to 0 until the cycle ends.
- R3: In a normal conversion, no serial clock rising edge occurs while BUSY is high. The readout starts only after BUSY has been seen high and then low.
- R4: Each readout or recovery run gives exactly 16 serial clock pulses. The serial clock idles high, and each pulse is a low phase then a high phase of SCLK_HALF cycles each.
- R5: The data line is sampled when the serial clock rises. The converter changes the data line after the clock falls. The 16 bits form a frame, first bit in frame bit 15. result takes frame bits 11..0, and result_valid is high for exactly one cycle per normal conversion, in the cycle ready returns to 1.
- R6: If any of frame bits 15..12 is 1, err_frame becomes 1 and stays 1 until reset. The result is still published.
- R7: Start requests made while ready is 0 are ignored: they cause no extra fall of the start strobe.
- R8: The start strobe is never low while serial clock pulses of a readout are in progress.
- R9: If BUSY has not finished its high-then-low sequence within BUSY_TIMEOUT cycles of the strobe returning high, the controller gives 16 serial clock pulses. It then sets err_timeout, which stays 1 until reset, and returns to ready without a result_valid pulse. This also covers the case where BUSY never rises.
- R10: After a timeout recovery, a later request performs a normal conversion with a correct result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_req | input | 1 | Request a conversion (taken only while ready) |
| ready | output | 1 | Controller idle and accepting a request |
| adc_conv_n | output | 1 | Active-low conversion start strobe to the converter |
| adc_busy | input | 1 | Converter BUSY status, synchronised inside |
| adc_sclk | output | 1 | Serial clock to the converter, idles high |
| adc_sdata | input | 1 | Serial data from the converter |
| result | output | 12 | Last conversion result |
| result_valid | output | 1 | One-cycle pulse when result is updated |
| err_timeout | output | 1 | Sticky flag: BUSY timeout recovery happened |
| err_frame | output | 1 | Sticky flag: a nonzero leading frame bit was read |

## Verification
The assertions assume that the converter changes the data line only after a falling serial clock edge. They also assume that BUSY, once it falls in a normal conversion, stays low until the next strobe. The bench's converter model meets both conditions: it is clocked by the system clock, it loads the frame when BUSY falls, and it shifts a bit out one cycle after each detected fall. That leaves at least two cycles before the sampling edge. The model's conversion time is well inside the bench's timeout. The stuck-high and never-rising BUSY cases are produced on purpose, and only in the recovery tests.

// File: rtl/adc_ctrl_pkg.sv
package adc_ctrl_pkg;

    localparam int FRAME_BITS = 16;
    localparam int DATA_BITS  = 12;
    localparam int LEAD_BITS  = FRAME_BITS - DATA_BITS;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CONV_LOW,
        ST_WAIT_HI,
        ST_WAIT_LO,
        ST_SHIFT,
        ST_PUBLISH,
        ST_FLUSH,
        ST_FAULT
    } ctrl_state_e;

endpackage

// File: rtl/busy_sync.sv
module busy_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], async_in};
    end

    assign sync_out = chain[STAGES-1];
endmodule

// File: rtl/sclk_gen.sv
module sclk_gen #(
    parameter int HALF   = 2,
    parameter int PULSES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic launch,
    output logic sclk,
    output logic running,
    output logic sample,
    output logic last
);
    localparam int HW = (HALF > 1) ? $clog2(HALF) : 1;
    localparam int PW = $clog2(PULSES + 1);

    logic [HW-1:0] hcnt;
    logic [PW-1:0] pcnt;
    logic          phase_end;

    assign phase_end = (hcnt == HW'(HALF - 1));
    assign sample    = running && !sclk && phase_end;
    assign last      = sample && (pcnt == PW'(PULSES - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            running <= 1'b0;
            sclk    <= 1'b1;
            hcnt    <= '0;
            pcnt    <= '0;
        end else if (launch) begin
            running <= 1'b1;
            sclk    <= 1'b0;
            hcnt    <= '0;
            pcnt    <= '0;
        end else if (running) begin
            if (phase_end) begin
                hcnt <= '0;
                sclk <= ~sclk;
                if (!sclk) begin
                    pcnt <= pcnt + 1'b1;
                    if (last) running <= 1'b0;
                end
            end else begin
                hcnt <= hcnt + 1'b1;
            end
        end
    end

    // R4
    relaunch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        launch |-> !running);
endmodule

// File: rtl/frame_shift.sv
module frame_shift #(
    parameter int BITS = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clear,
    input  logic            sample,
    input  logic            din,
    output logic [BITS-1:0] frame
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      frame <= '0;
        else if (clear)  frame <= '0;
        else if (sample) frame <= {frame[BITS-2:0], din};
    end
endmodule

// File: rtl/adc_conv_ctrl.sv
module adc_conv_ctrl
    import adc_ctrl_pkg::*;
#(
    parameter int START_LOW_CYC = 4,
    parameter int SCLK_HALF     = 2,
    parameter int BUSY_TIMEOUT  = 1200
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start_req,
    output logic                 ready,
    output logic                 adc_conv_n,
    input  logic                 adc_busy,
    output logic                 adc_sclk,
    input  logic                 adc_sdata,
    output logic [DATA_BITS-1:0] result,
    output logic                 result_valid,
    output logic                 err_timeout,
    output logic                 err_frame
);
    localparam int TMAX = (BUSY_TIMEOUT > START_LOW_CYC) ? BUSY_TIMEOUT : START_LOW_CYC;
    localparam int TW   = $clog2(TMAX + 1);

    ctrl_state_e           state, nx;
    logic [TW-1:0]         tmr;
    logic                  busy_s;
    logic                  tmo;
    logic                  launch;
    logic                  sclk_run, sclk_sample, sclk_last;
    logic [FRAME_BITS-1:0] frame;

    busy_sync #(.STAGES(2)) i_busy_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (adc_busy),
        .sync_out (busy_s)
    );

    sclk_gen #(.HALF(SCLK_HALF), .PULSES(FRAME_BITS)) i_sclk_gen (
        .clk     (clk),
        .rst_n   (rst_n),
        .launch  (launch),
        .sclk    (adc_sclk),
        .running (sclk_run),
        .sample  (sclk_sample),
        .last    (sclk_last)
    );

    frame_shift #(.BITS(FRAME_BITS)) i_frame_shift (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (launch),
        .sample (sclk_sample),
        .din    (adc_sdata),
        .frame  (frame)
    );

    assign tmo = (tmr == TW'(BUSY_TIMEOUT - 1));

    always_comb begin
        nx = state;
        unique case (state)
            ST_IDLE:     if (start_req) nx = ST_CONV_LOW;
            ST_CONV_LOW: if (tmr == TW'(START_LOW_CYC - 1)) nx = ST_WAIT_HI;
            ST_WAIT_HI: begin
                if (busy_s)   nx = ST_WAIT_LO;
                else if (tmo) nx = ST_FLUSH;
            end
            ST_WAIT_LO: begin
                if (!busy_s)  nx = ST_SHIFT;
                else if (tmo) nx = ST_FLUSH;
            end
            ST_SHIFT:    if (sclk_last) nx = ST_PUBLISH;
            ST_PUBLISH:  nx = ST_IDLE;
            ST_FLUSH:    if (sclk_last) nx = ST_FAULT;
            ST_FAULT:    nx = ST_IDLE;
            default:     nx = ST_IDLE;
        endcase
    end

    assign launch = (state != nx) && ((nx == ST_SHIFT) || (nx == ST_FLUSH));
    assign ready  = (state == ST_IDLE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmr <= '0;
        end else if ((state == ST_IDLE) || ((state == ST_CONV_LOW) && (nx != ST_CONV_LOW))) begin
            tmr <= '0;
        end else if (tmr != '1) begin
            tmr <= tmr + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            adc_conv_n   <= 1'b1;
            result       <= '0;
            result_valid <= 1'b0;
            err_timeout  <= 1'b0;
            err_frame    <= 1'b0;
        end else begin
            adc_conv_n   <= (nx != ST_CONV_LOW);
            result_valid <= 1'b0;
            if (state == ST_PUBLISH) begin
                result       <= frame[DATA_BITS-1:0];
                result_valid <= 1'b1;
                if (frame[FRAME_BITS-1 -: LEAD_BITS] != '0) err_frame <= 1'b1;
            end
            if (state == ST_FAULT) err_timeout <= 1'b1;
        end
    end

    // R2
    conv_from_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(adc_conv_n) |-> $past(ready));

    // R3
    sclk_only_in_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(adc_sclk) |-> ((state == ST_SHIFT) || (state == ST_FLUSH)));

    // R5
    valid_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid |=> !result_valid);

    // R7
    ignored_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ready && adc_conv_n) |=> adc_conv_n);

    // R8
    conv_idle_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !adc_conv_n |-> !sclk_run);

    // R9
    fault_no_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FAULT) |=> !result_valid);

    // R9
    timeout_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_timeout |=> err_timeout);

    // R6
    frame_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_frame |=> err_frame);
endmodule

// File: tb/test_adc_conv_ctrl.sv
`timescale 1ns/1ps
module test_adc_conv_ctrl;
    localparam int START_LOW = 4;
    localparam int HALF      = 3;
    localparam int TMO       = 300;
    localparam int CONV_CYC  = 40;
    localparam int NVEC      = 8;

    // each entry: {frame word, expected result, expected framing flag}
    localparam logic [28:0] VEC [NVEC] = '{
        {16'h0ABC, 12'hABC, 1'b0},
        {16'h0FFF, 12'hFFF, 1'b0},
        {16'h0000, 12'h000, 1'b0},
        {16'h0800, 12'h800, 1'b0},
        {16'h0001, 12'h001, 1'b0},
        {16'h0555, 12'h555, 1'b0},
        {16'h0AAA, 12'hAAA, 1'b0},
        {16'h9123, 12'h123, 1'b1}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_req = 1'b0;
    logic        ready, adc_conv_n, adc_sclk, result_valid, err_timeout, err_frame;
    logic        adc_busy = 1'b0;
    logic        adc_sdata = 1'b0;
    logic [11:0] result;

    int total = 0;
    int bad   = 0;
    bit finished = 0;

    // converter model controls
    int          mode = 0;           // 0 normal, 1 BUSY stuck high, 2 BUSY never rises
    logic [15:0] adc_word = '0;
    logic        clr = 1'b0;

    // converter model state and measurements
    logic        conv_q = 1'b1, sclk_q = 1'b1;
    logic [15:0] shreg = '0;
    int          ccnt = 0, srise = 0;
    int          nconv = 0, lowcyc = 0, pulses = 0, sclk_busy = 0, conv_in_frame = 0;

    always #5 clk = ~clk;

    adc_conv_ctrl #(
        .START_LOW_CYC (START_LOW),
        .SCLK_HALF     (HALF),
        .BUSY_TIMEOUT  (TMO)
    ) i_adc_conv_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_req    (start_req),
        .ready        (ready),
        .adc_conv_n   (adc_conv_n),
        .adc_busy     (adc_busy),
        .adc_sclk     (adc_sclk),
        .adc_sdata    (adc_sdata),
        .result       (result),
        .result_valid (result_valid),
        .err_timeout  (err_timeout),
        .err_frame    (err_frame)
    );

    always @(posedge clk) begin
        conv_q <= adc_conv_n;
        sclk_q <= adc_sclk;
        if (clr) begin
            nconv <= 0; lowcyc <= 0; pulses <= 0; sclk_busy <= 0; conv_in_frame <= 0;
        end else begin
            if (!adc_conv_n) lowcyc <= lowcyc + 1;
            if (conv_q && !adc_conv_n) nconv <= nconv + 1;
            if (!sclk_q && adc_sclk) begin
                pulses <= pulses + 1;
                if (adc_busy) sclk_busy <= sclk_busy + 1;
            end
            if (!adc_conv_n && pulses > 0 && pulses < 16) conv_in_frame <= conv_in_frame + 1;
        end
        if (conv_q && !adc_conv_n && mode != 2) begin
            adc_busy <= 1'b1;
            ccnt     <= 0;
            srise    <= 0;
        end else if (adc_busy) begin
            if (mode == 1) begin
                if (!sclk_q && adc_sclk) begin
                    if (srise == 15) adc_busy <= 1'b0;
                    srise <= srise + 1;
                end
            end else begin
                ccnt <= ccnt + 1;
                if (ccnt == CONV_CYC - 1) begin
                    adc_busy <= 1'b0;
                    shreg    <= adc_word;
                end
            end
        end
        if (sclk_q && !adc_sclk) begin
            adc_sdata <= shreg[15];
            shreg     <= {shreg[14:0], 1'b0};
        end
    end

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    int          vcnt;
    logic [11:0] got;
    bit          hung;

    task automatic run_conv(input logic [15:0] w, input int poke);
        int cyc;
        adc_word = w;
        @(negedge clk); clr = 1'b1;
        @(negedge clk); clr = 1'b0; start_req = 1'b1;
        @(negedge clk); start_req = 1'b0;
        vcnt = 0; got = '0; cyc = 0; hung = 0;
        while (!ready && cyc < 5000) begin
            @(negedge clk);
            cyc++;
            start_req = (poke != 0 && cyc == poke);
            if (result_valid) begin vcnt++; got = result; end
        end
        start_req = 1'b0;
        if (cyc >= 5000) hung = 1;
        repeat (3) begin
            @(negedge clk);
            if (result_valid) vcnt++;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        bit exp_ferr;
        repeat (3) @(negedge clk);
        // R1 reset state
        check(ready === 1'b1,        "R1 ready",        32'(ready), 1);
        check(adc_conv_n === 1'b1,   "R1 conv_n",       32'(adc_conv_n), 1);
        check(adc_sclk === 1'b1,     "R1 sclk",         32'(adc_sclk), 1);
        check(result === 12'h000,    "R1 result",       32'(result), 0);
        check(result_valid === 1'b0, "R1 valid",        32'(result_valid), 0);
        check(err_timeout === 1'b0,  "R1 err_timeout",  32'(err_timeout), 0);
        check(err_frame === 1'b0,    "R1 err_frame",    32'(err_frame), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        exp_ferr = 0;
        for (int i = 0; i < NVEC; i++) begin
            run_conv(VEC[i][28:13], 0);
            exp_ferr = exp_ferr | VEC[i][0];
            check(!hung,               "R2 completion",        32'(hung), 0);
            check(nconv == 1,          "R2 one strobe",        nconv, 1);
            check(lowcyc == START_LOW, "R2 strobe width",      lowcyc, START_LOW);
            check(sclk_busy == 0,      "R3 sclk during busy",  sclk_busy, 0);
            check(pulses == 16,        "R4 pulse count",       pulses, 16);
            check(adc_sclk === 1'b1,   "R4 sclk idle",         32'(adc_sclk), 1);
            check(vcnt == 1,           "R5 valid count",       vcnt, 1);
            check(got == VEC[i][12:1], "R5 result",            32'(got), 32'(VEC[i][12:1]));
            check(err_frame == exp_ferr, "R6 err_frame",       32'(err_frame), 32'(exp_ferr));
            check(conv_in_frame == 0,  "R8 strobe in frame",   conv_in_frame, 0);
            check(err_timeout == 1'b0, "R9 no timeout",        32'(err_timeout), 0);
        end

        // R7: request during conversion and during readout ignored
        run_conv(16'h0321, 20);
        check(nconv == 1,     "R7 poke in conversion", nconv, 1);
        check(got == 12'h321, "R7 result",             32'(got), 32'h321);
        run_conv(16'h0456, START_LOW + 3 + CONV_CYC + 10);
        check(nconv == 1,     "R7 poke in readout",    nconv, 1);
        check(conv_in_frame == 0, "R8 poke in readout", conv_in_frame, 0);
        repeat (50) @(negedge clk);
        check(nconv == 1 && ready, "R7 stays idle",    nconv, 1);

        // R9: BUSY stuck high
        mode = 1;
        run_conv(16'h0777, 0);
        check(!hung,              "R9 stuck completion", 32'(hung), 0);
        check(vcnt == 0,          "R9 stuck no valid",   vcnt, 0);
        check(pulses == 16,       "R9 stuck pulses",     pulses, 16);
        check(err_timeout == 1,   "R9 stuck flag",       32'(err_timeout), 1);
        check(adc_busy == 1'b0,   "R9 busy released",    32'(adc_busy), 0);
        check(result == 12'h456,  "R9 result held",      32'(result), 32'h456);

        // R9: BUSY never rises
        mode = 2;
        run_conv(16'h0111, 0);
        check(!hung,              "R9 norise completion", 32'(hung), 0);
        check(vcnt == 0,          "R9 norise no valid",   vcnt, 0);
        check(pulses == 16,       "R9 norise pulses",     pulses, 16);
        check(err_timeout == 1,   "R9 norise flag",       32'(err_timeout), 1);

        // R10: normal conversion after recovery
        mode = 0;
        run_conv(16'h0C3A, 0);
        check(vcnt == 1,          "R10 valid",       vcnt, 1);
        check(got == 12'hC3A,     "R10 result",      32'(got), 32'hC3A);
        check(pulses == 16,       "R10 pulses",      pulses, 16);
        check(sclk_busy == 0,     "R10 sclk busy",   sclk_busy, 0);
        check(err_timeout == 1,   "R10 flag sticky", 32'(err_timeout), 1);

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule